// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial write port for a small set of analog front-end control registers. It takes three signals: a load strobe, a shift clock and a serial data line. In the full device these share pins with the upper bits of the pixel output bus. A fourth signal, the line-start strobe, enables the port. While the line-start strobe is high, the bus pins act as inputs and the port accepts frames. While it is low, the port ignores the three wires and the bus may drive.

All inputs are asynchronous to the system clock. Each one is resynchronised and edge-detected in the system clock domain. The serial clock must therefore be slow compared with the system clock; each of its levels has to last at least three system clocks.

A frame opens on a falling load strobe. It collects a 3-bit register address followed by an 8-bit value, and commits the value on the rising load strobe. A frame commits only if exactly eleven bits arrived first; any bits beyond the eleventh are ignored. The register bank holds:
- three colour gain registers;
- three colour offset registers;
- a mode register with a self-clearing soft-reset bit and a power-down bit;
- a test register, whose output-disable bit gates the bus drive enable.

Top module: `ser_cfg_port`

## Requirements
- R1: A frame starts on a synchronised falling edge of `ld_i`. On each synchronised rising edge of `sclk_i`, the current `sdata_i` is shifted in. The first bit is address bit 2; the last bit is data bit 0. The frame is written on the next synchronised rising edge of `ld_i`, and the new value is visible at the outputs within six system clocks of that edge.
- R2: Address decoding is as follows:
  - 0: red gain
  - 1: red offset
  - 2: green gain
  - 3: green offset
  - 4: blue gain
  - 5: blue offset
  - 6: mode
  - 7: test

  A gain register stores data bits 7..2 as its 6-bit value; data bits 1..0 are discarded. The other registers store all eight bits.
- R3: If fewer than eleven shift-clock rising edges occur between the load fall and the load rise, no register changes.
- R4: Shift-clock rising edges after the eleventh in a frame are ignored. The first eleven bits decide the write.
- R5: The port acts only while `synch_i` is high. Frames sent while it is low leave every register unchanged. `bus_drive_en_o` is low whenever `synch_i` is high.
- R6: After `rst_n` is asserted, every gain register reads 0 and every offset register reads 0x40. The mode register reads 0x00, and the test register reads 0x00.
- R7: A mode write with bit 6 set returns all eight registers to their R6 values in a single step. The mode register then reads 0x00, so bit 6 reads back as 0.
- R8: A mode write with bit 7 set (power down) and bit 6 clear stores the value with bits 1..0 forced to 00.
- R9: Entering or leaving power down leaves the gain, offset and test registers unchanged.
- R10: While `synch_i` is low, `bus_drive_en_o` equals the inverse of test register bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| synch_i | input | 1 | Line-start strobe; high enables the serial port |
| ld_i | input | 1 | Load strobe; low frames a word, rising edge commits |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data, most significant bit first |
| gain_red_o | output | 6 | Red gain register |
| gain_grn_o | output | 6 | Green gain register |
| gain_blu_o | output | 6 | Blue gain register |
| ofs_red_o | output | 8 | Red offset register |
| ofs_grn_o | output | 8 | Green offset register |
| ofs_blu_o | output | 8 | Blue offset register |
| mode_o | output | 8 | Mode register |
| test_o | output | 8 | Test register |
| bus_drive_en_o | output | 1 | High when the shared data bus may be driven |

## Verification
All register contents are visible as ports. A wrong bit count or shift order therefore shows as a wrong register value within six clocks of the load rise. A frame of the wrong length that is committed anyway, or an address that is decoded wrongly, corrupts a neighbouring register; the check that compares every register after every frame catches this. Soft reset and power-down errors show as stale gain or offset values, or as a configuration field that is not 00, one frame later. A bus enable that does not follow the line-start strobe or the output-disable bit is sampled in the same frame.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int GAIN_W    = 6;
    localparam int MODE_PDN  = 7;
    localparam int MODE_SRST = 6;
    localparam int TEST_ODIS = 6;
    localparam int IN_SYNCH  = 0;
    localparam int IN_LD     = 1;
    localparam int IN_SCLK   = 2;
    localparam int IN_SDATA  = 3;
    localparam int IN_COUNT  = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_GAIN_R = 3'd0,
        A_OFS_R  = 3'd1,
        A_GAIN_G = 3'd2,
        A_OFS_G  = 3'd3,
        A_GAIN_B = 3'd4,
        A_OFS_B  = 3'd5,
        A_MODE   = 3'd6,
        A_TEST   = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4,
    parameter logic [WIDTH-1:0] IDLE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[STAGES-1:0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.pipe <= {(STAGES+1){IDLE}};
        else        s_q      <= s_d;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign lvl_o[b]  = s_q.pipe[STAGES-1][b];
        assign rise_o[b] = s_q.pipe[STAGES-1][b] & ~s_q.pipe[STAGES][b];
        assign fall_o[b] = ~s_q.pipe[STAGES-1][b] & s_q.pipe[STAGES][b];
    end
endmodule

// File: rtl/sercfg_rx.sv
module sercfg_rx #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ld_fall_i,
    input  logic              ld_rise_i,
    input  logic              sclk_rise_i,
    input  logic              sdata_i,
    output logic              wr_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [DATA_W-1:0] wdata_o
);
    localparam int FRAME_LEN = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_LEN);

    typedef struct packed {
        logic                 active;
        logic [CNT_W-1:0]     cnt;
        logic [FRAME_LEN-1:0] shreg;
        logic                 wr;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    data;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.wr = 1'b0;
        if (!en_i) begin
            r_d.active = 1'b0;
            r_d.cnt    = '0;
        end else if (ld_fall_i) begin
            r_d.active = 1'b1;
            r_d.cnt    = '0;
        end else if (r_q.active && ld_rise_i) begin
            r_d.active = 1'b0;
            if (r_q.cnt == FULL) begin
                r_d.wr   = 1'b1;
                r_d.addr = r_q.shreg[FRAME_LEN-1 -: ADDR_W];
                r_d.data = r_q.shreg[DATA_W-1:0];
            end
        end else if (r_q.active && sclk_rise_i && (r_q.cnt < FULL)) begin
            r_d.shreg = {r_q.shreg[FRAME_LEN-2:0], sdata_i};
            r_d.cnt   = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wr_o    = r_q.wr;
    assign waddr_o = r_q.addr;
    assign wdata_o = r_q.data;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= FULL); // R4
    AST_WR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wr |-> $past(r_q.cnt == FULL && r_q.active)); // R3
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
    import sercfg_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] OFS_RST = 8'h40
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic [2:0]                  addr_i,
    input  logic [DATA_W-1:0]           data_i,
    output logic [2:0][GAIN_W-1:0]      gain_o,
    output logic [2:0][DATA_W-1:0]      ofs_o,
    output logic [DATA_W-1:0]           mode_o,
    output logic [DATA_W-1:0]           test_o
);
    typedef struct packed {
        logic [2:0][GAIN_W-1:0] gain;
        logic [2:0][DATA_W-1:0] ofs;
        logic [DATA_W-1:0]      mode;
        logic [DATA_W-1:0]      test;
    } bank_t;

    localparam bank_t BANK_RST = '{gain: '0, ofs: {3{OFS_RST}}, mode: '0, test: '0};

    bank_t b_d, b_q;
    logic [1:0] chan;

    assign chan = addr_i[2:1];

    always_comb begin
        b_d = b_q;
        if (wr_i) begin
            if (chan != 2'b11) begin
                if (addr_i[0]) b_d.ofs[chan]  = data_i;
                else           b_d.gain[chan] = data_i[DATA_W-1 -: GAIN_W];
            end else if (!addr_i[0]) begin
                if (data_i[MODE_SRST]) begin
                    b_d = BANK_RST;
                end else begin
                    b_d.mode = data_i;
                    if (data_i[MODE_PDN]) b_d.mode[1:0] = 2'b00;
                end
            end else begin
                b_d.test = data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= BANK_RST;
        else        b_q <= b_d;
    end

    assign gain_o = b_q.gain;
    assign ofs_o  = b_q.ofs;
    assign mode_o = b_q.mode;
    assign test_o = b_q.test;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(b_q)); // R3
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MODE && data_i[MODE_SRST])
        |=> (b_q.mode == '0 && b_q.gain == '0 && b_q.ofs == {3{OFS_RST}})); // R7
    AST_PDN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MODE && data_i[MODE_PDN] && !data_i[MODE_SRST])
        |=> (b_q.mode[1:0] == 2'b00 && b_q.mode[MODE_PDN])); // R8
    AST_PDN_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MODE && !data_i[MODE_SRST])
        |=> ($stable(b_q.gain) && $stable(b_q.ofs) && $stable(b_q.test))); // R9
endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
    import sercfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int P_GAIN_W    = GAIN_W,
    parameter int P_DATA_W    = DATA_W,
    parameter logic [P_DATA_W-1:0] OFS_RST = 8'h40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                synch_i,
    input  logic                ld_i,
    input  logic                sclk_i,
    input  logic                sdata_i,
    output logic [P_GAIN_W-1:0] gain_red_o,
    output logic [P_GAIN_W-1:0] gain_grn_o,
    output logic [P_GAIN_W-1:0] gain_blu_o,
    output logic [P_DATA_W-1:0] ofs_red_o,
    output logic [P_DATA_W-1:0] ofs_grn_o,
    output logic [P_DATA_W-1:0] ofs_blu_o,
    output logic [P_DATA_W-1:0] mode_o,
    output logic [P_DATA_W-1:0] test_o,
    output logic                bus_drive_en_o
);
    localparam logic [IN_COUNT-1:0] IDLE_LVL = IN_COUNT'(1) << IN_LD;

    logic [IN_COUNT-1:0] raw, lvl, rise, fall;
    logic                wr;
    logic [ADDR_W-1:0]   waddr;
    logic [P_DATA_W-1:0] wdata;
    logic [2:0][P_GAIN_W-1:0] gain;
    logic [2:0][P_DATA_W-1:0] ofs;

    assign raw = {sdata_i, sclk_i, ld_i, synch_i};

    sercfg_sync #(.STAGES(SYNC_STAGES), .WIDTH(IN_COUNT), .IDLE(IDLE_LVL)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(raw),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    sercfg_rx #(.ADDR_W(ADDR_W), .DATA_W(P_DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .en_i(lvl[IN_SYNCH]),
        .ld_fall_i(fall[IN_LD]),
        .ld_rise_i(rise[IN_LD]),
        .sclk_rise_i(rise[IN_SCLK]),
        .sdata_i(lvl[IN_SDATA]),
        .wr_o(wr), .waddr_o(waddr), .wdata_o(wdata)
    );

    sercfg_regs #(.GAIN_W(P_GAIN_W), .DATA_W(P_DATA_W), .OFS_RST(OFS_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(wr), .addr_i(waddr), .data_i(wdata),
        .gain_o(gain), .ofs_o(ofs), .mode_o(mode_o), .test_o(test_o)
    );

    assign gain_red_o     = gain[0];
    assign gain_grn_o     = gain[1];
    assign gain_blu_o     = gain[2];
    assign ofs_red_o      = ofs[0];
    assign ofs_grn_o      = ofs[1];
    assign ofs_blu_o      = ofs[2];
    assign bus_drive_en_o = ~lvl[IN_SYNCH] & ~test_o[TEST_ODIS];

    AST_WR_IN_SYNCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> $past(lvl[IN_SYNCH])); // R5
endmodule

// File: tb/tb_ser_cfg_port.sv
module tb_ser_cfg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic synch = 1'b0, ld = 1'b1, sclk = 1'b0, sdata = 1'b0;
    logic [5:0] gain_r, gain_g, gain_b;
    logic [7:0] ofs_r, ofs_g, ofs_b, mode, test;
    logic bus_en;
    int total = 0;
    int bad = 0;

    logic [5:0] e_gain [3];
    logic [7:0] e_ofs  [3];
    logic [7:0] e_mode, e_test;

    always #10 clk = ~clk;

    ser_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .synch_i(synch), .ld_i(ld), .sclk_i(sclk), .sdata_i(sdata),
        .gain_red_o(gain_r), .gain_grn_o(gain_g), .gain_blu_o(gain_b),
        .ofs_red_o(ofs_r), .ofs_grn_o(ofs_g), .ofs_blu_o(ofs_b),
        .mode_o(mode), .test_o(test), .bus_drive_en_o(bus_en)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_defaults();
        for (int c = 0; c < 3; c++) begin
            e_gain[c] = 6'd0;
            e_ofs[c]  = 8'h40;
        end
        e_mode = 8'h00;
        e_test = 8'h00;
    endtask

    task automatic model_write(input logic [2:0] a, input logic [7:0] v);
        if (a < 3'd6) begin
            if (a[0]) e_ofs[a[2:1]]  = v;
            else      e_gain[a[2:1]] = v[7:2];
        end else if (a == 3'd6) begin
            if (v[6]) model_defaults();
            else begin
                e_mode = v;
                if (v[7]) e_mode[1:0] = 2'b00;
            end
        end else begin
            e_test = v;
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "gain_red", {2'b00, gain_r}, {2'b00, e_gain[0]});
        chk(req, "gain_grn", {2'b00, gain_g}, {2'b00, e_gain[1]});
        chk(req, "gain_blu", {2'b00, gain_b}, {2'b00, e_gain[2]});
        chk(req, "ofs_red", ofs_r, e_ofs[0]);
        chk(req, "ofs_grn", ofs_g, e_ofs[1]);
        chk(req, "ofs_blu", ofs_b, e_ofs[2]);
        chk(req, "mode", mode, e_mode);
        chk(req, "test", test, e_test);
        chk("R10", "bus_en", {7'd0, bus_en}, {7'd0, ~e_test[6]});
    endtask

    task automatic phase();
        repeat (3) @(negedge clk);
    endtask

    // Sends one frame of nclk shift clocks; bits past the eleventh are the inverse of word bits.
    task automatic send(input logic [2:0] a, input logic [7:0] v, input int nclk, input logic sy);
        logic [10:0] word;
        word  = {a, v};
        synch = sy;
        phase();
        if (sy) chk("R5", "bus_en while synch high", {7'd0, bus_en}, 8'd0);
        ld = 1'b0;
        phase();
        for (int i = 0; i < nclk; i++) begin
            sdata = (i < 11) ? word[10-i] : ~word[i % 11];
            sclk  = 1'b0;
            phase();
            sclk  = 1'b1;
            phase();
        end
        sclk = 1'b0;
        phase();
        ld = 1'b1;
        repeat (6) @(negedge clk);
        synch = 1'b0;
        phase();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] vals [6];
        vals = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'hC3};
        model_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase();
        check_all("R6");

        // R1 R2: sweep every address with several data patterns
        for (int a = 0; a < 8; a++) begin
            for (int k = 0; k < 6; k++) begin
                send(3'(a), vals[k] ^ 8'(a * 17), 11, 1'b1);
                model_write(3'(a), vals[k] ^ 8'(a * 17));
                check_all("R2");
            end
        end

        // R3: short frames leave everything unchanged
        send(3'd1, 8'h99, 10, 1'b1);
        check_all("R3");
        send(3'd4, 8'hF0, 0, 1'b1);
        check_all("R3");

        // R4: extra clocks are ignored
        send(3'd3, 8'h6B, 14, 1'b1);
        model_write(3'd3, 8'h6B);
        check_all("R4");
        send(3'd0, 8'hE4, 20, 1'b1);
        model_write(3'd0, 8'hE4);
        check_all("R4");

        // R5: frame with synch low is ignored
        send(3'd5, 8'h12, 11, 1'b0);
        check_all("R5");

        // R7: soft reset
        send(3'd2, 8'hFC, 11, 1'b1);
        model_write(3'd2, 8'hFC);
        send(3'd6, 8'h4B, 11, 1'b1);
        model_write(3'd6, 8'h4B);
        check_all("R7");
        chk("R7", "mode after soft reset", mode, 8'h00);

        // R8 R9: power down clears configuration, keeps other registers
        send(3'd6, 8'h07, 11, 1'b1);
        model_write(3'd6, 8'h07);
        send(3'd4, 8'hA8, 11, 1'b1);
        model_write(3'd4, 8'hA8);
        send(3'd6, 8'h8F, 11, 1'b1);
        model_write(3'd6, 8'h8F);
        chk("R8", "mode in power down", mode, 8'h8C);
        check_all("R9");
        send(3'd6, 8'h05, 11, 1'b1);
        model_write(3'd6, 8'h05);
        chk("R9", "gain_blu after power up", {2'b00, gain_b}, 8'h2A);
        check_all("R9");

        // R10: output disable bit
        send(3'd7, 8'h40, 11, 1'b1);
        model_write(3'd7, 8'h40);
        chk("R10", "bus_en disabled", {7'd0, bus_en}, 8'd0);
        send(3'd7, 8'h80, 11, 1'b1);
        model_write(3'd7, 8'h80);
        chk("R10", "bus_en enabled", {7'd0, bus_en}, 8'd1);
        check_all("R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule